// File: doc/BRIEF.md
# Dual Trimmed Tick Counter with Match Pulses

The block holds two independent up-counters that advance on a slow reference tick, which arrives as a one-cycle enable pulse in the fast bus clock domain and runs at about 32.768 kHz. Each counter has its own prescaler. The prescaler divides the tick by a programmable 16-bit divisor, and a per-counter bypass bit skips it. Each counter also has three compare values. When the count steps onto one of them, the block raises a one-cycle pulse on that comparator's output line.

Software writes the divisor, a load value, the three compare values and the shared control word through a simple register port. Reads have one cycle of latency, and software can read the live count at any time. A write never acts at once. It lands in a holding copy and raises a pending flag, and the value is copied into the working register on the next reference tick. Software polls the pending flags in the control word to learn when a write has reached the counter.

Top module: `dual_trim_counter`

## Requirements
- R1: After reset every count, holding value, control bit and pending flag reads 0, and `match_pulse` is 0.
- R2: A bus write to any register sets its pending flag, which reads back as 1 from the next cycle on. The flag clears at the first later reference tick that does not coincide with a new write to the same register.
- R3: A written divisor, load or compare value has no effect on counting until the pending flag clears. Until then the live count keeps its old value, and a read of the register returns the newly written holding value.
- R4: With enable and bypass both set, the count rises by exactly 1 on every reference tick.
- R5: With bypass clear and divisor N, the count rises once every N ticks when N is 2 or more. A divisor of 0 or 1 means every tick.
- R6: While a counter is disabled, its count and prescaler hold and none of its match pulses fire.
- R7: When an enabled count steps to a value equal to one of its compare values, the matching output bit is 1 for exactly one clock cycle, and only once per such step.
- R8: The two counters are independent. Counting, loading or matching on one never changes the other's count.
- R9: A pending load is applied at the next tick. It takes precedence over an increment on that tick, restarts the prescaler and produces no match pulse.
- R10: Control word layout: bit 2c is the enable and bit 2c+1 is the bypass of counter c. Bits 8+8c+k are the pending flags of counter c, with k=0 for the control fields, 1 for the divisor, 2 to 4 for compares 0 to 2, and 5 for the load. A control write sets the control pending flag of both counters.
- R11: Register addresses are fixed. Counter 0 uses divisor 0x00, load 0x04, compares 0x08/0x0C/0x10 and live count 0x40. Counter 1 uses divisor 0x44, load 0x48, compares 0x4C/0x50/0x54 and live count 0x58. The control word is at 0x14. A write that coincides with a tick stays pending until the following tick.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_re` and holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| match_pulse | output | 6 | Match pulses, bit 3c+k for compare k of counter c |

## Verification
The counters are run with the bypass set, with a divisor of 3 and with a divisor of 0. The first shows a step on every tick, the second a step on every third tick, and the third shows that a zero divisor does not stall the count. The pending flags are read before and after each copying tick, and once for a write that lands on a tick, which separates a deferred commit from an immediate one. Loads are placed on ticks where an increment would also occur, and compares are placed on values that the counter crosses while disabled and then again while enabled. These cases separate a correct design from one with a wrong priority or a missing enable gate.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int NUM_CNT   = 2;
  localparam int NUM_MATCH = 3;
  localparam int NUM_PEND  = NUM_MATCH + 3;
  localparam int ADDR_W    = 7;
  localparam int PEND_BASE = 8;
  localparam int PEND_STEP = 8;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_TRIM,
    RK_LOAD,
    RK_MATCH,
    RK_CTRL,
    RK_LIVE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic       idx;
    logic [1:0] sel;
  } reg_dec_t;

  function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_dec_t d;
    d.kind = RK_NONE;
    d.idx  = 1'b0;
    d.sel  = 2'd0;
    case (a)
      7'h00: d.kind = RK_TRIM;
      7'h04: d.kind = RK_LOAD;
      7'h08: begin d.kind = RK_MATCH; d.sel = 2'd0; end
      7'h0C: begin d.kind = RK_MATCH; d.sel = 2'd1; end
      7'h10: begin d.kind = RK_MATCH; d.sel = 2'd2; end
      7'h14: d.kind = RK_CTRL;
      7'h40: d.kind = RK_LIVE;
      7'h44: begin d.kind = RK_TRIM; d.idx = 1'b1; end
      7'h48: begin d.kind = RK_LOAD; d.idx = 1'b1; end
      7'h4C: begin d.kind = RK_MATCH; d.idx = 1'b1; d.sel = 2'd0; end
      7'h50: begin d.kind = RK_MATCH; d.idx = 1'b1; d.sel = 2'd1; end
      7'h54: begin d.kind = RK_MATCH; d.idx = 1'b1; d.sel = 2'd2; end
      7'h58: begin d.kind = RK_LIVE; d.idx = 1'b1; end
      default: d.kind = RK_NONE;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/dtc_shadow.sv
// Holding copy plus working copy of one register; the working copy only
// moves on a reference tick while a write is pending.
module dtc_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      active  <= '0;
      pending <= 1'b0;
    end else if (wr) begin
      shadow  <= wdata;
      pending <= 1'b1;
    end else if (tick && pending) begin
      active  <= shadow;
      pending <= 1'b0;
    end
  end

  p_pending_set_r2: assert property (@(posedge clk) disable iff (rst)
    wr |=> pending);
  p_pending_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && pending && !wr) |=> !pending);
  p_active_waits_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(active));
endmodule

// File: rtl/dtc_prescaler.sv
module dtc_prescaler #(
  parameter int TRIM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              bypass,
  input  logic              clear,
  input  logic [TRIM_W-1:0] divisor,
  output logic              step
);
  logic [TRIM_W-1:0] presc;
  logic [TRIM_W:0]   presc_nxt;
  logic              wrap;

  assign presc_nxt = {1'b0, presc} + 1'b1;
  assign wrap      = presc_nxt >= {1'b0, divisor};
  assign step      = tick && run && !clear && (bypass || wrap);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      presc <= '0;
    end else if (tick && run && !bypass) begin
      presc <= wrap ? '0 : presc_nxt[TRIM_W-1:0];
    end
  end

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(presc));
endmodule

// File: rtl/dtc_unit.sv
module dtc_unit
  import dtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TRIM_W = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                tick,
  input  logic                                wr_ctrl,
  input  logic [1:0]                          ctrl_wdata,
  input  logic                                wr_trim,
  input  logic [TRIM_W-1:0]                   trim_wdata,
  input  logic                                wr_load,
  input  logic [NUM_MATCH-1:0]                wr_match,
  input  logic [CNT_W-1:0]                    val_wdata,
  output logic [CNT_W-1:0]                    count,
  output logic [1:0]                          ctrl_view,
  output logic [TRIM_W-1:0]                   trim_view,
  output logic [CNT_W-1:0]                    load_view,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]     match_view,
  output logic [NUM_PEND-1:0]                 pend,
  output logic [NUM_MATCH-1:0]                pulse
);
  logic [1:0]                      ctrl_act;
  logic [TRIM_W-1:0]               trim_act;
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_act;
  logic [NUM_MATCH-1:0]            match_pend;
  logic                            ctrl_pend, trim_pend, load_pend;
  logic                            load_now, step, en, byp;
  logic [CNT_W-1:0]                cnt_inc;

  dtc_shadow #(.W(2)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr_ctrl), .wdata(ctrl_wdata),
    .shadow(ctrl_view), .active(ctrl_act), .pending(ctrl_pend)
  );

  dtc_shadow #(.W(TRIM_W)) u_trim (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr_trim), .wdata(trim_wdata),
    .shadow(trim_view), .active(trim_act), .pending(trim_pend)
  );

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_match
    dtc_shadow #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst(rst), .tick(tick), .wr(wr_match[k]), .wdata(val_wdata),
      .shadow(match_view[k]), .active(match_act[k]), .pending(match_pend[k])
    );
  end

  // The load value is consumed by the counter itself, so it has no working copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      load_view <= '0;
      load_pend <= 1'b0;
    end else if (wr_load) begin
      load_view <= val_wdata;
      load_pend <= 1'b1;
    end else if (tick && load_pend) begin
      load_pend <= 1'b0;
    end
  end

  assign en       = ctrl_act[0];
  assign byp      = ctrl_act[1];
  assign load_now = tick && load_pend && !wr_load;
  assign cnt_inc  = count + 1'b1;
  assign pend     = {load_pend, match_pend, trim_pend, ctrl_pend};

  dtc_prescaler #(.TRIM_W(TRIM_W)) u_presc (
    .clk(clk), .rst(rst), .tick(tick), .run(en), .bypass(byp),
    .clear(load_now), .divisor(trim_act), .step(step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_now) begin
      count <= load_view;
    end else if (step) begin
      count <= cnt_inc;
    end
  end

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_hit
    always_ff @(posedge clk) begin
      if (rst) pulse[k] <= 1'b0;
      else     pulse[k] <= step && (cnt_inc == match_act[k]);
    end

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
      pulse[k] |=> !pulse[k]);
  end

  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!en && !load_now) |=> $stable(count));
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pulse == '0));
  p_bypass_step_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && en && byp && !load_now) |=> (count == $past(count) + 1'b1));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    load_now |=> (count == $past(load_view)) && (pulse == '0));
endmodule

// File: rtl/dual_trim_counter.sv
module dual_trim_counter
  import dtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TRIM_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ref_tick,
  input  logic                           bus_we,
  input  logic                           bus_re,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [CNT_W-1:0]               bus_wdata,
  output logic [CNT_W-1:0]               bus_rdata,
  output logic [NUM_CNT*NUM_MATCH-1:0]   match_pulse
);
  reg_dec_t                        dec;
  logic [CNT_W-1:0]                cnt_v   [NUM_CNT];
  logic [1:0]                      ctrl_v  [NUM_CNT];
  logic [TRIM_W-1:0]               trim_v  [NUM_CNT];
  logic [CNT_W-1:0]                load_v  [NUM_CNT];
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_v [NUM_CNT];
  logic [NUM_PEND-1:0]             pend_v  [NUM_CNT];
  logic [CNT_W-1:0]                ctrl_rd;
  logic                            wr_ctrl;

  assign dec     = decode_addr(bus_addr);
  assign wr_ctrl = bus_we && (dec.kind == RK_CTRL);

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    logic [NUM_MATCH-1:0] wr_m;
    logic                 sel_me;

    assign sel_me = bus_we && (dec.idx == 1'(c));
    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_wm
      assign wr_m[k] = sel_me && (dec.kind == RK_MATCH) && (dec.sel == 2'(k));
    end

    dtc_unit #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_unit (
      .clk        (clk),
      .rst        (rst),
      .tick       (ref_tick),
      .wr_ctrl    (wr_ctrl),
      .ctrl_wdata (bus_wdata[2*c +: 2]),
      .wr_trim    (sel_me && (dec.kind == RK_TRIM)),
      .trim_wdata (bus_wdata[TRIM_W-1:0]),
      .wr_load    (sel_me && (dec.kind == RK_LOAD)),
      .wr_match   (wr_m),
      .val_wdata  (bus_wdata),
      .count      (cnt_v[c]),
      .ctrl_view  (ctrl_v[c]),
      .trim_view  (trim_v[c]),
      .load_view  (load_v[c]),
      .match_view (match_v[c]),
      .pend       (pend_v[c]),
      .pulse      (match_pulse[c*NUM_MATCH +: NUM_MATCH])
    );
  end

  always_comb begin
    ctrl_rd = '0;
    for (int c = 0; c < NUM_CNT; c++) begin
      ctrl_rd[2*c +: 2] = ctrl_v[c];
      ctrl_rd[PEND_BASE + PEND_STEP*c +: NUM_PEND] = pend_v[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (dec.kind)
        RK_TRIM:  bus_rdata <= CNT_W'(trim_v[dec.idx]);
        RK_LOAD:  bus_rdata <= load_v[dec.idx];
        RK_MATCH: bus_rdata <= match_v[dec.idx][dec.sel];
        RK_CTRL:  bus_rdata <= ctrl_rd;
        RK_LIVE:  bus_rdata <= cnt_v[dec.idx];
        default:  bus_rdata <= '0;
      endcase
    end
  end

  p_read_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));
  p_ctrl_write_marks_r10: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (pend_v[0][0] && pend_v[1][0]));
endmodule

// File: tb/dual_trim_counter_test.sv
module dual_trim_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  match_pulse;

  always #5 clk = ~clk;

  dual_trim_counter uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_we(bus_we),
    .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .match_pulse(match_pulse)
  );

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        re_q = 1'b0;
  int          pcount[6] = '{default: 0};

  // monitor side of the scoreboard
  always @(posedge clk) begin
    re_q <= bus_re;
    if (!rst) for (int i = 0; i < 6; i++) if (match_pulse[i]) pcount[i]++;
  end

  always @(negedge clk) begin
    if (re_q) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_tick(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; ref_tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; ref_tick = 1'b0;
  endtask

  // driver side: push expectation, issue the read
  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    chk(int'(match_pulse), 0, "R1 pulses after reset");
    rd(7'h14, 32'h0, "R1 control after reset");
    rd(7'h40, 32'h0, "R1 count0 after reset");
    rd(7'h58, 32'h0, "R1 count1 after reset");
    rd(7'h0C, 32'h0, "R1 compare after reset");

    wr(7'h00, 32'd3);
    rd(7'h14, 32'h0000_0200, "R2 divisor pending set");
    rd(7'h00, 32'd3, "R3 divisor holding read");
    tick(1);
    rd(7'h14, 32'h0, "R2 divisor pending cleared");

    wr(7'h04, 32'd100);
    rd(7'h40, 32'd0, "R3 load not yet applied");
    tick(1);
    rd(7'h40, 32'd100, "R3 load applied at tick");

    wr(7'h0C, 32'd102);
    tick(1);
    wr(7'h14, 32'h1);
    rd(7'h14, 32'h0001_0101, "R10 control write marks both");
    tick(1);
    rd(7'h14, 32'h1, "R10 enable committed");
    tick(6);
    rd(7'h40, 32'd102, "R5 divide by 3");
    chk(pcount[1], 1, "R7 compare1 hit");
    tick(3);
    rd(7'h40, 32'd103, "R5 divide by 3 further");
    chk(pcount[1], 1, "R7 single pulse");

    wr(7'h14, 32'h0);
    tick(1);
    wr(7'h08, 32'd104);
    tick(7);
    rd(7'h40, 32'd103, "R6 disabled holds");
    chk(pcount[0], 0, "R6 no pulse when disabled");

    wr(7'h54, 32'd3);
    wr(7'h14, 32'hC);
    tick(1);
    tick(5);
    rd(7'h58, 32'd5, "R4 bypass every tick");
    rd(7'h40, 32'd103, "R8 counter0 untouched");
    chk(pcount[5], 1, "R7 counter1 compare2");
    chk(pcount[2], 0, "R8 no cross pulse");

    wr(7'h00, 32'd0);
    wr(7'h14, 32'hD);
    tick(1);
    tick(4);
    rd(7'h40, 32'd107, "R5 divisor zero every tick");
    rd(7'h58, 32'd10, "R8 counter1 own pace");
    chk(pcount[0], 1, "R7 compare0 after enable");

    wr(7'h10, 32'd201);
    tick(1);
    wr(7'h04, 32'd200);
    tick(1);
    rd(7'h40, 32'd200, "R9 load beats increment");
    chk(pcount[2], 0, "R9 no pulse on load");
    tick(1);
    idle(2);
    rd(7'h40, 32'd201, "R9 prescaler restarted");
    chk(pcount[2], 1, "R7 compare2 after load");

    wr_tick(7'h44, 32'd7);
    rd(7'h14, 32'h0002_000D, "R11 write on tick stays pending");
    rd(7'h44, 32'd7, "R11 divisor1 address");
    tick(1);
    rd(7'h14, 32'h0000_000D, "R11 committed next tick");
    rd(7'h14, 32'h0000_000D, "R12 back to back read");

    idle(3);
    chk(exp_q.size(), 0, "R12 all reads answered");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule